// File: doc/BRIEF.md
# Character Raster Timing Generator

This block derives every raster timing signal for a text display of 80 columns by 16 rows from one dot-clock input. A chain of four counters tracks the dot within a character cell, the character column, the scan line inside a character row, and the character row. Sync, blanking and a shift-register load strobe are decoded from that position. The column, scan-line and row counts are also exported so that neighbouring logic can form display-memory addresses.

Each scan line spans 113 character times of 8 dots; the first 80 characters are visible. Each character row has 12 scan lines, 8 carrying glyph dots and 4 forming a blank gap. A frame has 22 rows, of which 16 are shown. When the processor takes the shared display memory, the composite blank is raised at once and held for one further character time after the request ends. This covers the memory and glyph-ROM latency. All decoded outputs and counts are flopped, so they all move on the same clock edge.

Top module: `crt_text_timer`

## Requirements
- R1: `char_load` is high for exactly one dot clock, the first dot (dot count 0) of every 8-dot character cell, and low on the other 7 dots.
- R2: `col_idx` advances by one after the 8th dot of a cell. It counts 0 to 112 and then returns to 0, so a scan line is 113 character times (904 dot clocks).
- R3: `line_idx` advances by one when the column wraps from 112 to 0. It counts 0 to 11 and then returns to 0.
- R4: `row_idx` advances by one when the scan line wraps from 11 to 0. It counts 0 to ROWS_TOTAL-1 (default 21) and then returns to 0, which starts a new frame.
- R5: `hsync` is high exactly while `col_idx` is in the range 88 to 95 inclusive, which is 8 character times inside the horizontal blanking interval.
- R6: `vsync` is high for every dot of character row VS_ROW (default 18) and low in all other rows.
- R7: `csync` is high exactly when `hsync` or `vsync` is high.
- R8: `blank` is high whenever `col_idx` is 80 or more, `line_idx` is 8 or more, or `row_idx` is ROWS_VIS (default 16) or more.
- R9: If `cpu_access` is sampled high at a clock edge, `blank` is high after that edge. After the last edge that samples it high, `blank` stays high for that edge's output and the following 7 dot clocks (8 dot clocks in all). It then falls unless R8 holds. `cpu_access` has no effect on the counts.
- R10: While `rst_n` is low, all counts are 0. `char_load` is 1, `blank`, `hsync`, `vsync` and `csync` are 0, and any pending access stretch is cleared. The first edge after release moves the position to dot 1 of column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_access | input | 1 | High while the processor is using the shared display memory |
| char_load | output | 1 | Strobe on the first dot of each character cell |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| csync | output | 1 | Composite sync, active high |
| blank | output | 1 | Composite blanking, active high |
| col_idx | output | 7 | Character column, 0 to 112 |
| line_idx | output | 4 | Scan line within the character row, 0 to 11 |
| row_idx | output | 5 | Character row, 0 to 21 |

## Verification
A wrong dot or column count shows on `char_load` or `col_idx` within at most 8 dot clocks. A wrong scan-line or row count takes longer to appear at the ports: it shows on `line_idx` or `row_idx` at the next column or line wrap, up to 904 or 10848 clocks later. For this reason the bench compares every output on every dot across a full frame plus its wrap. It uses a reduced row count so that the frame fits the run. A fault in the access stretch is visible only inside the 8-dot window after `cpu_access` falls. That window is therefore probed on the last stretched dot and on the first dot after it.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef struct packed {
    logic load;
    logic hs;
    logic vs;
    logic cs;
    logic blank;
  } vtg_flags_t;

  function automatic logic in_window(input int unsigned v, input int unsigned lo,
                                     input int unsigned len);
    return (v >= lo) && (v < lo + len);
  endfunction

  function automatic logic at_or_past(input int unsigned v, input int unsigned lim);
    return v >= lim;
  endfunction

endpackage

// File: rtl/vtg_mod_counter.sv
module vtg_mod_counter #(
  parameter int unsigned MOD = 8,
  localparam int unsigned W = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt,
  output logic         last
);

  assign last = (q == W'(MOD - 1));

  always_comb begin
    nxt = q;
    if (en) nxt = last ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R2, R3, R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !last) |=> (q == W'($past(q) + 1'b1)));

  // R2, R3, R4
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last) |=> (q == '0));

  // R2, R3, R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
  import vtg_pkg::*;
#(
  parameter int unsigned DW = 3,
  parameter int unsigned CW = 7,
  parameter int unsigned LW = 4,
  parameter int unsigned RW = 5,
  parameter int unsigned COLS_VIS = 80,
  parameter int unsigned HS_START = 88,
  parameter int unsigned HS_LEN = 8,
  parameter int unsigned LINES_VIS = 8,
  parameter int unsigned ROWS_VIS = 16,
  parameter int unsigned VS_ROW = 18
) (
  input  logic [DW-1:0] dot,
  input  logic [CW-1:0] col,
  input  logic [LW-1:0] line,
  input  logic [RW-1:0] row,
  input  logic          hold,
  output vtg_flags_t    flags
);

  always_comb begin
    flags.load  = (dot == '0);
    flags.hs    = in_window(32'(col), HS_START, HS_LEN);
    flags.vs    = (32'(row) == VS_ROW);
    flags.cs    = flags.hs | flags.vs;
    flags.blank = at_or_past(32'(col), COLS_VIS) | at_or_past(32'(line), LINES_VIS)
                | at_or_past(32'(row), ROWS_VIS) | hold;
  end

endmodule

// File: rtl/vtg_access_stretch.sv
module vtg_access_stretch #(
  parameter int unsigned HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  output logic hold_nxt
);

  generate
    if (HOLD == 0) begin : g_direct
      assign hold_nxt = access;
    end else begin : g_count
      localparam int unsigned HW = $clog2(HOLD + 1);
      logic [HW-1:0] cnt_q, cnt_d;

      always_comb begin
        if (access)            cnt_d = HW'(HOLD);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = '0;
      end

      assign hold_nxt = (cnt_d != '0);

      always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      // R9
      stretch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> (cnt_q == HW'(HOLD)));

      // R9
      stretch_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!access && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    end
  endgenerate

endmodule

// File: rtl/crt_text_timer.sv
module crt_text_timer
  import vtg_pkg::*;
#(
  parameter int unsigned DOTS_PER_CHAR = 8,
  parameter int unsigned COLS_TOTAL    = 113,
  parameter int unsigned COLS_VIS      = 80,
  parameter int unsigned HS_START      = 88,
  parameter int unsigned HS_LEN        = 8,
  parameter int unsigned LINES_PER_ROW = 12,
  parameter int unsigned LINES_VIS     = 8,
  parameter int unsigned ROWS_TOTAL    = 22,
  parameter int unsigned ROWS_VIS      = 16,
  parameter int unsigned VS_ROW        = 18,
  localparam int unsigned DW = $clog2(DOTS_PER_CHAR),
  localparam int unsigned CW = $clog2(COLS_TOTAL),
  localparam int unsigned LW = $clog2(LINES_PER_ROW),
  localparam int unsigned RW = $clog2(ROWS_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_access,
  output logic          char_load,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic          blank,
  output logic [CW-1:0] col_idx,
  output logic [LW-1:0] line_idx,
  output logic [RW-1:0] row_idx
);

  localparam logic HS_AT_ZERO = in_window(0, HS_START, HS_LEN);
  localparam logic VS_AT_ZERO = (VS_ROW == 0);
  localparam vtg_flags_t FLAGS_AT_ZERO = '{load: 1'b1, hs: HS_AT_ZERO, vs: VS_AT_ZERO,
                                           cs: HS_AT_ZERO | VS_AT_ZERO, blank: 1'b0};

  logic [DW-1:0] dot_q, dot_nxt;
  logic [CW-1:0] col_nxt;
  logic [LW-1:0] line_nxt;
  logic [RW-1:0] row_nxt;
  logic          dot_last, col_last, line_last, row_last;
  logic          line_step, row_step;
  logic          hold_nxt;
  vtg_flags_t    flags_nxt, flags_q;

  assign line_step = dot_last & col_last;
  assign row_step  = line_step & line_last;

  vtg_mod_counter #(.MOD(DOTS_PER_CHAR)) u_dot (
    .clk(clk), .rst_n(rst_n), .en(1'b1),
    .q(dot_q), .nxt(dot_nxt), .last(dot_last));

  vtg_mod_counter #(.MOD(COLS_TOTAL)) u_col (
    .clk(clk), .rst_n(rst_n), .en(dot_last),
    .q(col_idx), .nxt(col_nxt), .last(col_last));

  vtg_mod_counter #(.MOD(LINES_PER_ROW)) u_line (
    .clk(clk), .rst_n(rst_n), .en(line_step),
    .q(line_idx), .nxt(line_nxt), .last(line_last));

  vtg_mod_counter #(.MOD(ROWS_TOTAL)) u_row (
    .clk(clk), .rst_n(rst_n), .en(row_step),
    .q(row_idx), .nxt(row_nxt), .last(row_last));

  vtg_access_stretch #(.HOLD(DOTS_PER_CHAR)) u_stretch (
    .clk(clk), .rst_n(rst_n), .access(cpu_access), .hold_nxt(hold_nxt));

  vtg_decode #(
    .DW(DW), .CW(CW), .LW(LW), .RW(RW),
    .COLS_VIS(COLS_VIS), .HS_START(HS_START), .HS_LEN(HS_LEN),
    .LINES_VIS(LINES_VIS), .ROWS_VIS(ROWS_VIS), .VS_ROW(VS_ROW)
  ) u_decode (
    .dot(dot_nxt), .col(col_nxt), .line(line_nxt), .row(row_nxt),
    .hold(hold_nxt), .flags(flags_nxt));

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= FLAGS_AT_ZERO;
    else        flags_q <= flags_nxt;
  end

  assign char_load = flags_q.load;
  assign hsync     = flags_q.hs;
  assign vsync     = flags_q.vs;
  assign csync     = flags_q.cs;
  assign blank     = flags_q.blank;

  // R1
  load_first_dot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_load == (dot_q == '0));

  // R4
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_step && row_last) |=> (row_idx == '0));

  // R5
  hsync_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync == ((32'(col_idx) >= HS_START) && (32'(col_idx) < HS_START + HS_LEN)));

  // R7
  csync_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csync == (hsync || vsync));

  // R8
  blank_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(col_idx) >= COLS_VIS) || (32'(line_idx) >= LINES_VIS)
     || (32'(row_idx) >= ROWS_VIS)) |-> blank);

  // R9
  access_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_access |=> blank);

endmodule

// File: tb/tb_crt_text_timer.sv
`timescale 1ns/1ps
module tb_crt_text_timer;

  localparam int TD  = 8;
  localparam int TC  = 113;
  localparam int TCV = 80;
  localparam int THS = 88;
  localparam int THL = 8;
  localparam int TL  = 12;
  localparam int TLV = 8;
  localparam int TR  = 6;
  localparam int TRV = 4;
  localparam int TVR = 5;
  localparam int TRW = $clog2(TR);
  localparam int LINE_DOTS  = TD * TC;
  localparam int ROW_DOTS   = LINE_DOTS * TL;
  localparam int FRAME_DOTS = ROW_DOTS * TR;

  localparam int NPTS = 21;
  localparam int PTS [NPTS] = '{0, 1, 7, 8, 9, 639, 640, 704, 767, 768, 903, 904,
                                7231, 7232, 10847, 10848, 43392, 54240, 54944,
                                65087, 65088};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_access = 1'b0;
  logic char_load, hsync, vsync, csync, blank;
  logic [6:0] col_idx;
  logic [3:0] line_idx;
  logic [TRW-1:0] row_idx;

  int n = 0;
  int checks = 0;
  int errors = 0;
  int mon_err = 0;
  int mon_cnt = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  crt_text_timer #(
    .ROWS_TOTAL(TR), .ROWS_VIS(TRV), .VS_ROW(TVR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cpu_access(cpu_access),
    .char_load(char_load), .hsync(hsync), .vsync(vsync), .csync(csync),
    .blank(blank), .col_idx(col_idx), .line_idx(line_idx), .row_idx(row_idx));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) n = 0;
    else        n = n + 1;
  end

  function automatic int e_dot(input int m);  return m % TD; endfunction
  function automatic int e_col(input int m);  return (m / TD) % TC; endfunction
  function automatic int e_line(input int m); return (m / LINE_DOTS) % TL; endfunction
  function automatic int e_row(input int m);  return (m / ROW_DOTS) % TR; endfunction
  function automatic int e_hs(input int m);
    return (e_col(m) >= THS && e_col(m) <= THS + THL - 1) ? 1 : 0;
  endfunction
  function automatic int e_vs(input int m); return (e_row(m) == TVR) ? 1 : 0; endfunction
  function automatic int e_blank(input int m);
    return (e_col(m) >= TCV || e_line(m) >= TLV || e_row(m) >= TRV) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at n=%0d: actual=%0d expected=%0d", tag, n, act, exp);
    end
  endtask

  task automatic chk_all(input int m);
    chk("R1 char_load", int'(char_load), (e_dot(m) == 0) ? 1 : 0);
    chk("R2 col_idx", int'(col_idx), e_col(m));
    chk("R3 line_idx", int'(line_idx), e_line(m));
    chk("R4 row_idx", int'(row_idx), e_row(m));
    chk("R5 hsync", int'(hsync), e_hs(m));
    chk("R6 vsync", int'(vsync), e_vs(m));
    chk("R7 csync", int'(csync), (e_hs(m) + e_vs(m) != 0) ? 1 : 0);
    chk("R8 blank", int'(blank), e_blank(m));
  endtask

  // Dot-by-dot comparison over a full frame (R1..R8 together).
  always @(negedge clk) begin
    if (mon_en) begin
      mon_cnt++;
      if (int'(char_load) != ((e_dot(n) == 0) ? 1 : 0) || int'(col_idx) != e_col(n)
          || int'(line_idx) != e_line(n) || int'(row_idx) != e_row(n)
          || int'(hsync) != e_hs(n) || int'(vsync) != e_vs(n)
          || int'(csync) != ((e_hs(n) + e_vs(n) != 0) ? 1 : 0)
          || int'(blank) != e_blank(n))
        mon_err++;
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog at n=%0d: actual=timeout expected=completion", n);
    finish_run();
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    // R10: state while reset is held
    chk("R10 reset col", int'(col_idx), 0);
    chk("R10 reset row", int'(row_idx), 0);
    chk("R10 reset load", int'(char_load), 1);
    chk("R10 reset blank", int'(blank), 0);
    rst_n = 1'b1;
    mon_en = 1'b1;

    for (int i = 0; i < NPTS; i++) begin
      while (n != PTS[i]) @(negedge clk);
      chk_all(PTS[i]);
    end
    mon_en = 1'b0;
    chk("R1-frame sweep mismatches", mon_err, 0);
    chk("R2 sweep length", (mon_cnt >= FRAME_DOTS) ? 1 : 0, 1);

    // R9: access stretch on a visible position (frame 2, column 10)
    n0 = FRAME_DOTS + 10 * TD;
    while (n != n0) @(negedge clk);
    chk("R9 blank before access", int'(blank), 0);
    cpu_access = 1'b1;
    @(negedge clk);
    chk("R9 blank after first access edge", int'(blank), 1);
    chk("R9 col unaffected by access", int'(col_idx), e_col(n));
    repeat (2) @(negedge clk);
    cpu_access = 1'b0;
    repeat (7) @(negedge clk);
    chk("R9 blank on last stretched dot", int'(blank), 1);
    @(negedge clk);
    chk("R9 blank after stretch", int'(blank), 0);
    chk("R9 counts unaffected", int'(col_idx), e_col(n));

    // R10: reset mid-line clears counts and pending stretch
    repeat (5) @(negedge clk);
    cpu_access = 1'b1;
    @(negedge clk);
    cpu_access = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 mid reset col", int'(col_idx), 0);
    chk("R10 mid reset line", int'(line_idx), 0);
    chk("R10 mid reset load", int'(char_load), 1);
    rst_n = 1'b1;
    chk("R10 stretch cleared", int'(blank), 0);
    @(negedge clk);
    chk("R10 first dot after release load", int'(char_load), 0);
    chk("R10 first dot after release col", int'(col_idx), 0);
    chk("R10 first dot after release blank", int'(blank), 0);
    finish_run();
  end

endmodule